// File: doc/BRIEF.md
# Data Bus Line Test Engine

This block is a hardware sequencer that checks a 64-bit memory data path for lines that are shorted together or open. It drives a simple synchronous memory port and walks a fixed list of twelve 64-bit stripe patterns. Each stripe width from 1 to 32 bits is used once, and each stripe is used again in complemented form, so that every pair of data lines is driven to opposite levels at least once, whatever the board routing.

For every pattern the engine writes the pattern to one target word. It then writes a fixed filler word to the word just above the target, so that charge left on a floating bus is replaced before the read-back. Finally it reads the target exactly once. The captured read value is compared with the pattern, and the same captured value is reported on a log port when the two differ.

All twelve patterns run even after a failure. A sticky error flag and a one-cycle done pulse summarise the run. A debug input flips one bit of the captured data, so that the detection path can be exercised on good memory.

Top module: `dbus_line_tester`

## Requirements
- R1: After reset, busy, done, error, mem_req and log_valid are all low.
- R2: For each pattern the engine makes three accepted bus transfers in this order: a write of the pattern to the target word; a write of the filler 0x0123456789ABCDEF to the target address plus one, modulo 2^ADDR_W; a read of the target word. A transfer is accepted on a cycle where mem_req and mem_ready are both high. While a request waits for mem_ready, mem_req, mem_we, mem_addr and mem_wdata are held stable.
- R3: The patterns are applied in stripe order AAAAAAAAAAAAAAAA, CCCCCCCCCCCCCCCC, F0F0F0F0F0F0F0F0, FF00FF00FF00FF00, FFFF0000FFFF0000, FFFFFFFF00000000, and then as complements 00000000FFFFFFFF, 0000FFFF0000FFFF, 00FF00FF00FF00FF, 0F0F0F0F0F0F0F0F, 3333333333333333, 5555555555555555, all in hex.
- R4: Exactly one read is issued per pattern, twelve per run. No new request is issued while a read is outstanding, and the engine waits for mem_rvalid for as many cycles as the read takes.
- R5: On a mismatch, log_valid pulses for one cycle. The pulse carries the target address in log_addr, the written pattern in log_expected, and the single captured read value in log_actual.
- R6: All twelve patterns are applied even after a mismatch. The error output goes high with the first mismatch and holds until a later start is accepted, which clears it.
- R7: done is a one-cycle pulse on the cycle busy falls, and error is already final on that cycle.
- R8: A start pulse while busy is ignored: the run in progress is not restarted and no second run follows.
- R9: While inject_err is high, bit INJ_BIT (default 15) of the captured read data is inverted before the compare and the log.
- R10: target_addr is sampled when a start is accepted. The same target is used for every pattern even if the input changes during the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse; accepted only while idle |
| target_addr | input | ADDR_W | Word address of the target word |
| inject_err | input | 1 | Debug: invert bit INJ_BIT of captured read data |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Sticky mismatch flag for the last run |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 64 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| log_valid | output | 1 | One-cycle mismatch report strobe |
| log_addr | output | ADDR_W | Failing target address |
| log_expected | output | 64 | Pattern that was written |
| log_actual | output | 64 | Value that was captured |

## Verification
The bench builds the engine with ADDR_W = 6 and the default INJ_BIT of 15, and pairs it with a 64-word memory model. The small address space puts the top word within reach, so a target there makes the filler write wrap to word 0. The model can stall mem_ready pseudo-randomly, delay read data by up to three cycles, hold a data bit at zero, or drop every write so that the bus keeps its last driven value. Each fault yields a mismatch set that the bench can predict from the pattern list.

// File: rtl/dbus_test_pkg.sv
package dbus_test_pkg;

    localparam int WORD_W     = 64;
    localparam int STRIPE_CNT = $clog2(WORD_W);
    localparam int NUM_PAT    = 2 * STRIPE_CNT;
    localparam int PAT_IDX_W  = $clog2(NUM_PAT);

    localparam logic [WORD_W-1:0] FILLER_WORD = 64'h0123_4567_89AB_CDEF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_PAT,
        ST_WR_FILL,
        ST_RD_REQ,
        ST_RD_WAIT
    } seq_state_e;

    // Bus operation requested by the sequencer
    typedef struct packed {
        logic req;
        logic we;
        logic sel_fill;   // address target+1 and drive the filler word
    } bus_op_t;

    // Word whose bit i is bit k of i: stripes of width 2^k, high half first
    function automatic logic [WORD_W-1:0] stripe_word(input int unsigned k);
        logic [WORD_W-1:0] w;
        for (int unsigned i = 0; i < WORD_W; i++) begin
            w[i] = (((i >> k) & 1) == 1);
        end
        return w;
    endfunction

endpackage

// File: rtl/dbus_pattern_rom.sv
module dbus_pattern_rom
    import dbus_test_pkg::*;
(
    input  logic [PAT_IDX_W-1:0] idx,
    output logic [WORD_W-1:0]    pattern
);

    logic [WORD_W-1:0] table_w [NUM_PAT];

    // First half: widening stripes; second half: complements, widest first
    for (genvar g = 0; g < NUM_PAT; g++) begin : g_pat
        if (g < STRIPE_CNT) begin : g_base
            assign table_w[g] = stripe_word(g);
        end else begin : g_inv
            assign table_w[g] = ~stripe_word(NUM_PAT - 1 - g);
        end
    end

    always_comb begin
        pattern = '0;
        if (idx < PAT_IDX_W'(NUM_PAT)) begin
            pattern = table_w[idx];
        end
    end

endmodule

// File: rtl/dbus_seq_fsm.sv
module dbus_seq_fsm
    import dbus_test_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 mem_ready,
    input  logic                 mem_rvalid,
    output bus_op_t              op,
    output logic [PAT_IDX_W-1:0] pat_idx,
    output logic                 run_start,
    output logic                 cmp_en,
    output logic                 busy,
    output logic                 done
);

    localparam logic [PAT_IDX_W-1:0] LAST_IDX = PAT_IDX_W'(NUM_PAT - 1);

    seq_state_e state_q;

    assign busy      = (state_q != ST_IDLE);
    assign run_start = (state_q == ST_IDLE) && start;
    assign cmp_en    = (state_q == ST_RD_WAIT) && mem_rvalid;

    always_comb begin
        op = '0;
        unique case (state_q)
            ST_WR_PAT:  op = '{req: 1'b1, we: 1'b1, sel_fill: 1'b0};
            ST_WR_FILL: op = '{req: 1'b1, we: 1'b1, sel_fill: 1'b1};
            ST_RD_REQ:  op = '{req: 1'b1, we: 1'b0, sel_fill: 1'b0};
            default:    op = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pat_idx <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_WR_PAT;
                        pat_idx <= '0;
                    end
                end
                ST_WR_PAT:  if (mem_ready) state_q <= ST_WR_FILL;
                ST_WR_FILL: if (mem_ready) state_q <= ST_RD_REQ;
                ST_RD_REQ:  if (mem_ready) state_q <= ST_RD_WAIT;
                ST_RD_WAIT: begin
                    if (mem_rvalid) begin
                        if (pat_idx == LAST_IDX) begin
                            state_q <= ST_IDLE;
                            done    <= 1'b1;
                        end else begin
                            pat_idx <= pat_idx + 1'b1;
                            state_q <= ST_WR_PAT;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dbus_result_log.sv
module dbus_result_log
    import dbus_test_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int INJ_BIT = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              cmp_en,
    input  logic              inject,
    input  logic [WORD_W-1:0] rdata,
    input  logic [WORD_W-1:0] expected,
    input  logic [ADDR_W-1:0] addr,
    output logic              log_valid,
    output logic [ADDR_W-1:0] log_addr,
    output logic [WORD_W-1:0] log_expected,
    output logic [WORD_W-1:0] log_actual,
    output logic              error
);

    localparam logic [WORD_W-1:0] INJ_MASK = WORD_W'(1) << INJ_BIT;

    // The single captured read value feeds both the compare and the log
    logic [WORD_W-1:0] captured;
    assign captured = inject ? (rdata ^ INJ_MASK) : rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            log_valid    <= 1'b0;
            log_addr     <= '0;
            log_expected <= '0;
            log_actual   <= '0;
            error        <= 1'b0;
        end else begin
            log_valid <= 1'b0;
            if (clr) begin
                error <= 1'b0;
            end else if (cmp_en && (captured != expected)) begin
                log_valid    <= 1'b1;
                log_addr     <= addr;
                log_expected <= expected;
                log_actual   <= captured;
                error        <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dbus_line_tester.sv
module dbus_line_tester
    import dbus_test_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int INJ_BIT = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] target_addr,
    input  logic              inject_err,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [63:0]       mem_rdata,
    output logic              log_valid,
    output logic [ADDR_W-1:0] log_addr,
    output logic [63:0]       log_expected,
    output logic [63:0]       log_actual
);

    bus_op_t              op;
    logic [PAT_IDX_W-1:0] pat_idx;
    logic                 run_start;
    logic                 cmp_en;
    logic [WORD_W-1:0]    pattern;
    logic [ADDR_W-1:0]    tgt_q;

    dbus_seq_fsm u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .mem_ready  (mem_ready),
        .mem_rvalid (mem_rvalid),
        .op         (op),
        .pat_idx    (pat_idx),
        .run_start  (run_start),
        .cmp_en     (cmp_en),
        .busy       (busy),
        .done       (done)
    );

    dbus_pattern_rom u_rom (
        .idx     (pat_idx),
        .pattern (pattern)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q <= '0;
        end else if (run_start) begin
            tgt_q <= target_addr;
        end
    end

    assign mem_req   = op.req;
    assign mem_we    = op.we;
    assign mem_addr  = op.sel_fill ? (tgt_q + ADDR_W'(1)) : tgt_q;
    assign mem_wdata = op.sel_fill ? FILLER_WORD : pattern;

    dbus_result_log #(
        .ADDR_W  (ADDR_W),
        .INJ_BIT (INJ_BIT)
    ) u_log (
        .clk          (clk),
        .rst          (rst),
        .clr          (run_start),
        .cmp_en       (cmp_en),
        .inject       (inject_err),
        .rdata        (mem_rdata),
        .expected     (pattern),
        .addr         (tgt_q),
        .log_valid    (log_valid),
        .log_addr     (log_addr),
        .log_expected (log_expected),
        .log_actual   (log_actual),
        .error        (error)
    );

endmodule

// File: rtl/dbus_line_tester_chk.sv
module dbus_line_tester_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              error,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [63:0]       mem_wdata,
    input logic              mem_ready,
    input logic              mem_rvalid,
    input logic              log_valid
);

    // Reads accepted on the port but not yet answered
    logic [1:0] rd_out;
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_out <= '0;
        end else begin
            rd_out <= rd_out + {1'b0, (mem_req && mem_ready && !mem_we)}
                             - {1'b0, (mem_rvalid && rd_out != 2'd0)};
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    a_r2_hold_req: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we)
                                     && $stable(mem_addr) && $stable(mem_wdata)));

    a_r4_one_read: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (rd_out == 2'd0));

    a_r5_log_sets_error: assert property (@(posedge clk) disable iff (rst)
        log_valid |-> error);

    a_r5_log_in_run: assert property (@(posedge clk) disable iff (rst)
        log_valid |-> (busy || done));

    a_r6_error_sticky: assert property (@(posedge clk) disable iff (rst)
        (error && !start) |=> error);

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_done_on_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

endmodule

bind dbus_line_tester dbus_line_tester_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .error      (error),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ready  (mem_ready),
    .mem_rvalid (mem_rvalid),
    .log_valid  (log_valid)
);

// File: tb/dbus_line_tester_tb.sv
module dbus_line_tester_tb_top;

    localparam int AW = 6;
    localparam logic [63:0] FILL = 64'h0123_4567_89AB_CDEF;

    // R3: expected pattern order
    localparam logic [63:0] EXP_PAT [12] = '{
        64'hAAAA_AAAA_AAAA_AAAA, 64'hCCCC_CCCC_CCCC_CCCC,
        64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00,
        64'hFFFF_0000_FFFF_0000, 64'hFFFF_FFFF_0000_0000,
        64'h0000_0000_FFFF_FFFF, 64'h0000_FFFF_0000_FFFF,
        64'h00FF_00FF_00FF_00FF, 64'h0F0F_0F0F_0F0F_0F0F,
        64'h3333_3333_3333_3333, 64'h5555_5555_5555_5555
    };

    // Scenario vectors: stimulus knobs and expected mismatch count
    localparam int          NSC = 5;
    localparam int          SC_TGT    [NSC] = '{5, 63, 10, 20, 33};
    localparam bit          SC_STALL  [NSC] = '{0, 1, 0, 1, 0};
    localparam int          SC_LAT    [NSC] = '{0, 3, 1, 2, 0};
    localparam logic [63:0] SC_STUCK  [NSC] = '{0, 0, 64'h0000_0100_0000_0000, 0, 0};
    localparam bit          SC_BROKEN [NSC] = '{0, 0, 0, 1, 0};
    localparam bit          SC_INJ    [NSC] = '{0, 0, 0, 0, 1};
    localparam int          SC_NLOG   [NSC] = '{0, 0, 6, 12, 12};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [AW-1:0] target_addr = '0;
    logic inject_err = 1'b0;
    logic busy, done, error, mem_req, mem_we, log_valid;
    logic [AW-1:0] mem_addr, log_addr;
    logic [63:0] mem_wdata, log_expected, log_actual;
    logic mem_ready, mem_rvalid;
    logic [63:0] mem_rdata;

    always #2 clk = ~clk;

    dbus_line_tester #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .target_addr(target_addr),
        .inject_err(inject_err), .busy(busy), .done(done), .error(error),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .log_valid(log_valid), .log_addr(log_addr),
        .log_expected(log_expected), .log_actual(log_actual)
    );

    // Memory model knobs
    bit          k_stall = 0;
    bit          k_broken = 0;
    int          k_lat = 0;
    logic [63:0] k_stuck0 = '0;

    logic [63:0] mem [64];
    logic [63:0] bus_hold;
    logic        rdy_q, rvalid_q, rd_pend;
    logic [63:0] rdata_q;
    logic [AW-1:0] rd_addr;
    int          rd_cnt;
    logic [7:0]  lfsr;

    assign mem_ready  = rdy_q;
    assign mem_rvalid = rvalid_q;
    assign mem_rdata  = rdata_q;

    always @(posedge clk) begin
        if (rst) begin
            rdy_q    <= 1'b0;
            rvalid_q <= 1'b0;
            rd_pend  <= 1'b0;
            rd_cnt   <= 0;
            rdata_q  <= '0;
            bus_hold <= '0;
            lfsr     <= 8'hA5;
        end else begin
            lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            rdy_q    <= !k_stall || lfsr[0] || lfsr[2];
            rvalid_q <= 1'b0;
            if (rd_pend) begin
                if (rd_cnt == 0) begin
                    rvalid_q <= 1'b1;
                    rdata_q  <= k_broken ? bus_hold : (mem[rd_addr] & ~k_stuck0);
                    rd_pend  <= 1'b0;
                end else begin
                    rd_cnt <= rd_cnt - 1;
                end
            end
            if (mem_req && rdy_q) begin
                if (mem_we) begin
                    if (!k_broken) mem[mem_addr] <= mem_wdata;
                    bus_hold <= mem_wdata;
                end else begin
                    rd_pend <= 1'b1;
                    rd_cnt  <= k_lat;
                    rd_addr <= mem_addr;
                end
            end
        end
    end

    // Recorders
    logic        rec_clr = 1'b0;
    int          ntx, nlog, ndone, nreads, done_busy_bad;
    logic        tx_we   [64];
    logic [AW-1:0] tx_addr [64];
    logic [63:0] tx_data [64];
    logic [AW-1:0] lg_addr [16];
    logic [63:0] lg_exp  [16];
    logic [63:0] lg_act  [16];

    always @(posedge clk) begin
        if (rec_clr) begin
            ntx <= 0; nlog <= 0; ndone <= 0; nreads <= 0; done_busy_bad <= 0;
        end else begin
            if (mem_req && mem_ready) begin
                if (ntx < 64) begin
                    tx_we[ntx]   <= mem_we;
                    tx_addr[ntx] <= mem_addr;
                    tx_data[ntx] <= mem_wdata;
                end
                ntx <= ntx + 1;
                if (!mem_we) nreads <= nreads + 1;
            end
            if (log_valid) begin
                if (nlog < 16) begin
                    lg_addr[nlog] <= log_addr;
                    lg_exp[nlog]  <= log_expected;
                    lg_act[nlog]  <= log_actual;
                end
                nlog <= nlog + 1;
            end
            if (done) begin
                ndone <= ndone + 1;
                if (busy) done_busy_bad <= done_busy_bad + 1;
            end
        end
    end

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic clear_rec();
        @(negedge clk) rec_clr = 1'b1;
        @(negedge clk) rec_clr = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (ndone == 0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        check(ndone != 0, "R7", "run completion (watchdog)", 64'(ndone), 64'd1);
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [63:0] model_read(input int sc, input logic [63:0] pat);
        if (SC_BROKEN[sc]) return FILL;
        if (SC_INJ[sc])    return pat ^ (64'd1 << 15);
        return pat & ~SC_STUCK[sc];
    endfunction

    initial begin
        #590000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(busy == 0, "R1", "busy after reset", 64'(busy), 64'd0);
        check(done == 0, "R1", "done after reset", 64'(done), 64'd0);
        check(error == 0, "R1", "error after reset", 64'(error), 64'd0);
        check(mem_req == 0, "R1", "mem_req after reset", 64'(mem_req), 64'd0);
        check(log_valid == 0, "R1", "log_valid after reset", 64'(log_valid), 64'd0);
        @(negedge clk) rst = 1'b0;
        repeat (2) @(negedge clk);

        // Vector table walk
        for (int sc = 0; sc < NSC; sc++) begin
            int bad_tx;
            int bad_log;
            int j;
            k_stall     = SC_STALL[sc];
            k_lat       = SC_LAT[sc];
            k_stuck0    = SC_STUCK[sc];
            k_broken    = SC_BROKEN[sc];
            inject_err  = SC_INJ[sc];
            target_addr = AW'(SC_TGT[sc]);
            clear_rec();
            pulse_start();
            wait_done();
            // R2 R3 R10: transfer order, addresses and data
            bad_tx = 0;
            for (int p = 0; p < 12; p++) begin
                logic [AW-1:0] t;
                t = AW'(SC_TGT[sc]);
                if (!(tx_we[3*p] && tx_addr[3*p] == t && tx_data[3*p] == EXP_PAT[p])) bad_tx++;
                if (!(tx_we[3*p+1] && tx_addr[3*p+1] == AW'(t + 1'b1) && tx_data[3*p+1] == FILL)) bad_tx++;
                if (!(!tx_we[3*p+2] && tx_addr[3*p+2] == t)) bad_tx++;
            end
            check(ntx == 36, "R2", $sformatf("transfer count sc%0d", sc), 64'(ntx), 64'd36);
            check(bad_tx == 0, "R3", $sformatf("transfer sequence sc%0d", sc), 64'(bad_tx), 64'd0);
            check(nreads == 12, "R4", $sformatf("read count sc%0d", sc), 64'(nreads), 64'd12);
            check(ndone == 1 && done_busy_bad == 0, "R7",
                  $sformatf("done pulse sc%0d", sc), 64'(ndone), 64'd1);
            check(error == (SC_NLOG[sc] != 0), "R6", $sformatf("error flag sc%0d", sc),
                  64'(error), 64'(SC_NLOG[sc] != 0));
            check(nlog == SC_NLOG[sc], "R6", $sformatf("mismatch count sc%0d", sc),
                  64'(nlog), 64'(SC_NLOG[sc]));
            // R5 R9: log contents
            bad_log = 0;
            j = 0;
            for (int p = 0; p < 12; p++) begin
                logic [63:0] a;
                a = model_read(sc, EXP_PAT[p]);
                if (a != EXP_PAT[p]) begin
                    if (j >= 16 || lg_addr[j] != AW'(SC_TGT[sc]) ||
                        lg_exp[j] != EXP_PAT[p] || lg_act[j] != a) bad_log++;
                    j++;
                end
            end
            check(bad_log == 0, SC_INJ[sc] ? "R9" : "R5",
                  $sformatf("log contents sc%0d", sc), 64'(bad_log), 64'd0);
        end

        // R6: error holds after a failing run until the next start
        repeat (10) @(negedge clk);
        check(error == 1, "R6", "error held while idle", 64'(error), 64'd1);
        k_stall = 0; k_lat = 0; k_stuck0 = '0; k_broken = 0; inject_err = 0;
        target_addr = AW'(12);
        clear_rec();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(busy == 1 && error == 0, "R6", "error cleared on start",
              64'(error), 64'd0);
        // R8 / R10: start while busy and target change mid-run are ignored
        repeat (8) @(negedge clk);
        target_addr = AW'(40);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait_done();
        repeat (20) @(negedge clk);
        check(ntx == 36, "R8", "no restart from start while busy", 64'(ntx), 64'd36);
        check(ndone == 1 && busy == 0, "R8", "single done, idle after", 64'(ndone), 64'd1);
        begin
            int bad = 0;
            for (int i = 0; i < 36; i++) begin
                if ((i % 3) != 1 && tx_addr[i] != AW'(12)) bad++;
            end
            check(bad == 0, "R10", "target held across input change", 64'(bad), 64'd0);
        end
        check(error == 0 && nlog == 0, "R5", "clean run has no reports", 64'(nlog), 64'd0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule